// File: doc/BRIEF.md
# Banked I/O Expander Register File

This block is the register core of a general-purpose port expander with up to 40 pins, grouped into 8-bit banks. For each bank it keeps four registers: a sampled input, an output latch, a polarity-inversion mask and a direction mask. It drives the pin output values and output enables from these registers and samples the pin levels every clock.

A host decoder in front of it, outside this block, presents a byte-wide strobe bus. A start strobe carries a command byte. Bit 7 of that byte requests auto-increment, and bits 6:0 hold a register pointer. Later write strobes each carry one data byte. Read strobes each return one byte, and a stop strobe closes the transaction. The pointer packs the register index above a bank field, so a multi-byte burst with auto-increment walks through the banks of one register.

The sequencer has three named states. HS_IDLE means no transaction is open. HS_ARMED means a command has been taken but no data has moved. HS_STREAM means at least one data byte has moved. A start in any state goes to HS_ARMED (the "arm" transition). A write or read in HS_ARMED goes to HS_STREAM (the "first data" transition), and further bytes keep it in HS_STREAM. A stop from HS_ARMED or HS_STREAM goes to HS_IDLE (the "close" transition). In HS_IDLE, data strobes leave it in HS_IDLE. If strobes coincide, start wins over stop, stop wins over write, and write wins over read.

Top module: `gpx_bank_regs`

## Requirements
- R1: After reset every output latch bit is 1, every direction bit is 1 (so no pin is driven), every inversion bit is 0, and hb_rvalid is 0.
- R2: The pointer in command bits 6:0 equals (register index << S) + bank, where S = ceil(log2(NBANKS)) (3 for five banks). The register indices are 0 input, 1 output, 2 inversion and 3 direction. Bit 7 of the command is the auto-increment flag.
- R3: A write byte to the output, inversion or direction register of bank b replaces that register. Pin n belongs to bank n/8 at bit n%8. The new value appears on the pins in the cycle after the write strobe.
- R4: A direction bit of 0 sets the pin's output enable and drives the output latch bit onto pin_out. A direction bit of 1 clears the enable.
- R5: A read strobe returns the addressed byte on hb_rdata, with hb_rvalid high, in the cycle after the strobe. An input-register read returns the pin level, registered once, XOR the inversion bit.
- R6: A write to the input register changes no register. Later reads return the same values as before, and the pins do not change.
- R7: With auto-increment set, each data byte moves the pointer to the next bank of the same register, and the last bank wraps to bank 0.
- R8: With auto-increment clear, every data byte of the transaction uses the same register and bank.
- R9: Write and read strobes while no transaction is open (after reset or after a stop) are ignored and return no read data.
- R10: A pointer whose register index is above 3, or whose bank is NBANKS or more, ignores writes and reads as 0x00.
- R11: A start in the middle of a transaction replaces the pointer and flag without a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hb_start | input | 1 | Start strobe; hb_byte is the command |
| hb_stop | input | 1 | Stop strobe; closes the transaction |
| hb_wr | input | 1 | Write strobe; hb_byte is the data |
| hb_rd | input | 1 | Read strobe |
| hb_byte | input | 8 | Command or write data byte |
| hb_rdata | output | 8 | Read data |
| hb_rvalid | output | 1 | Read data valid, one cycle after hb_rd |
| pin_in | input | 8*NBANKS | Pin levels |
| pin_out | output | 8*NBANKS | Pin output values |
| pin_oe | output | 8*NBANKS | Pin output enables |

## Verification
Every strobe is held for one cycle, so a written register and the pins it drives change at the next edge and are valid one cycle after the strobe. Read data is registered once and so is also valid one cycle after hb_rd. Pin levels pass through one sampling register, so the bench waits at least one cycle after changing pin_in before it reads the input register. The driver queues each expected read byte when it issues the strobe. A monitor samples on the falling edge, so each byte is compared in exactly the cycle it is due, and any valid byte with no queued expectation is a failure.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    typedef enum logic [1:0] {
        RIX_INPUT  = 2'd0,
        RIX_OUTPUT = 2'd1,
        RIX_INVERT = 2'd2,
        RIX_DIR    = 2'd3
    } rix_t;

    typedef enum logic [1:0] {
        HS_IDLE   = 2'd0,
        HS_ARMED  = 2'd1,
        HS_STREAM = 2'd2
    } hs_state_t;

    localparam int AUTOINC_BIT = 7;
    localparam int BANK_BITS   = 8;

endpackage

// File: rtl/gpx_host_seq.sv
module gpx_host_seq
    import gpx_pkg::*;
#(
    parameter int NBANKS = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 stop,
    input  logic                 wr,
    input  logic                 rd,
    input  logic [7:0]           cmd,
    output logic                 acc_wr,
    output logic                 acc_rd,
    output logic                 acc_hit,
    output rix_t                 acc_rix,
    output logic [((NBANKS > 1) ? $clog2(NBANKS) : 1)-1:0] acc_bank
);
    localparam int SHIFT = $clog2(NBANKS);
    localparam int BW    = (SHIFT > 0) ? SHIFT : 1;
    localparam logic [6:0] BMASK = 7'((1 << SHIFT) - 1);
    localparam logic [6:0] NB7   = 7'(NBANKS);
    localparam logic [6:0] LAST7 = 7'(NBANKS - 1);

    hs_state_t  state, state_nx;
    logic [6:0] ptr;
    logic       ai;
    logic [6:0] reg_field, bank_field, bank_nx;
    logic       data_ev;

    // Pointer fields
    always_comb begin
        reg_field  = ptr >> SHIFT;
        bank_field = ptr & BMASK;
        bank_nx    = (bank_field >= LAST7) ? 7'd0 : bank_field + 7'd1;
    end

    assign data_ev = (state != HS_IDLE) && !start && !stop && (wr || rd);

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            HS_IDLE:   if (start) state_nx = HS_ARMED;
            HS_ARMED: begin
                if (start)        state_nx = HS_ARMED;
                else if (stop)    state_nx = HS_IDLE;
                else if (wr || rd) state_nx = HS_STREAM;
            end
            HS_STREAM: begin
                if (start)     state_nx = HS_ARMED;
                else if (stop) state_nx = HS_IDLE;
            end
            default: state_nx = HS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= HS_IDLE;
        else        state <= state_nx;
    end

    // Pointer register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
            ai  <= 1'b0;
        end else if (start) begin
            ptr <= cmd[6:0];
            ai  <= cmd[AUTOINC_BIT];
        end else if (data_ev && ai) begin
            ptr <= (reg_field << SHIFT) | bank_nx;
        end
    end

    // Outputs
    always_comb begin
        acc_wr   = data_ev && wr;
        acc_rd   = data_ev && rd && !wr;
        acc_hit  = (reg_field < 7'd4) && (bank_field < NB7);
        acc_rix  = rix_t'(reg_field[1:0]);
        acc_bank = BW'(bank_field);
    end

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HS_IDLE && !start) |=> (state == HS_IDLE));
    p_start_arms_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == HS_ARMED));
    p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ev && !ai) |=> $stable(ptr));
    p_bank_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ev && ai && bank_field == LAST7) |=> (bank_field == 7'd0));

endmodule

// File: rtl/gpx_bank_slice.sv
module gpx_bank_slice
    import gpx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  rix_t         wr_rix,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_lvl,
    output logic [W-1:0] out_q,
    output logic [W-1:0] inv_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] smp_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '1;
            inv_q <= '0;
            dir_q <= '1;
        end else if (wr_en) begin
            unique case (wr_rix)
                RIX_OUTPUT: out_q <= wdata;
                RIX_INVERT: inv_q <= wdata;
                RIX_DIR:    dir_q <= wdata;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= pin_lvl;
    end

    p_input_write_inert_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_rix == RIX_INPUT) |=> ($stable(out_q) && $stable(inv_q) && $stable(dir_q)));

endmodule

// File: rtl/gpx_bank_regs.sv
module gpx_bank_regs
    import gpx_pkg::*;
#(
    parameter int NBANKS = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          hb_start,
    input  logic                          hb_stop,
    input  logic                          hb_wr,
    input  logic                          hb_rd,
    input  logic [7:0]                    hb_byte,
    output logic [7:0]                    hb_rdata,
    output logic                          hb_rvalid,
    input  logic [BANK_BITS*NBANKS-1:0]   pin_in,
    output logic [BANK_BITS*NBANKS-1:0]   pin_out,
    output logic [BANK_BITS*NBANKS-1:0]   pin_oe
);
    localparam int SHIFT = $clog2(NBANKS);
    localparam int BW    = (SHIFT > 0) ? SHIFT : 1;

    logic          acc_wr, acc_rd, acc_hit;
    rix_t          acc_rix;
    logic [BW-1:0] acc_bank;

    logic [7:0] out_b [NBANKS];
    logic [7:0] inv_b [NBANKS];
    logic [7:0] dir_b [NBANKS];
    logic [7:0] smp_b [NBANKS];
    logic [7:0] rd_mux;

    gpx_host_seq #(.NBANKS(NBANKS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (hb_start),
        .stop     (hb_stop),
        .wr       (hb_wr),
        .rd       (hb_rd),
        .cmd      (hb_byte),
        .acc_wr   (acc_wr),
        .acc_rd   (acc_rd),
        .acc_hit  (acc_hit),
        .acc_rix  (acc_rix),
        .acc_bank (acc_bank)
    );

    for (genvar g = 0; g < NBANKS; g++) begin : g_bank
        logic sel;
        assign sel = acc_wr && acc_hit && (acc_bank == BW'(g));

        gpx_bank_slice #(.W(BANK_BITS)) u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (sel),
            .wr_rix  (acc_rix),
            .wdata   (hb_byte),
            .pin_lvl (pin_in[g*BANK_BITS +: BANK_BITS]),
            .out_q   (out_b[g]),
            .inv_q   (inv_b[g]),
            .dir_q   (dir_b[g]),
            .smp_q   (smp_b[g])
        );

        assign pin_out[g*BANK_BITS +: BANK_BITS] = out_b[g];
        assign pin_oe[g*BANK_BITS +: BANK_BITS]  = ~dir_b[g];
    end

    // Read selection
    always_comb begin
        rd_mux = 8'h00;
        for (int b = 0; b < NBANKS; b++) begin
            if (acc_hit && acc_bank == BW'(b)) begin
                unique case (acc_rix)
                    RIX_INPUT:  rd_mux = smp_b[b] ^ inv_b[b];
                    RIX_OUTPUT: rd_mux = out_b[b];
                    RIX_INVERT: rd_mux = inv_b[b];
                    RIX_DIR:    rd_mux = dir_b[b];
                    default:    rd_mux = 8'h00;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hb_rvalid <= 1'b0;
            hb_rdata  <= 8'h00;
        end else begin
            hb_rvalid <= acc_rd;
            if (acc_rd) hb_rdata <= rd_mux;
        end
    end

    p_rvalid_after_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hb_rvalid |-> $past(hb_rd));

endmodule

// File: tb/gpx_bank_regs_test.sv
`timescale 1ns/1ps
module gpx_bank_regs_test;
    localparam int NB = 5;
    localparam int NP = 8 * NB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hb_start = 0, hb_stop = 0, hb_wr = 0, hb_rd = 0;
    logic [7:0]    hb_byte = 8'h00;
    logic [7:0]    hb_rdata;
    logic          hb_rvalid;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;

    always #10 clk = ~clk;

    gpx_bank_regs #(.NBANKS(NB)) uut (
        .clk(clk), .rst_n(rst_n),
        .hb_start(hb_start), .hb_stop(hb_stop), .hb_wr(hb_wr), .hb_rd(hb_rd),
        .hb_byte(hb_byte), .hb_rdata(hb_rdata), .hb_rvalid(hb_rvalid),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    int         n_tests = 0;
    int         n_fail  = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: compares each returned byte against the queue
    always @(negedge clk) begin
        if (rst_n && hb_rvalid) begin
            if (exp_q.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL R9: actual unexpected read %h expected no data", hb_rdata);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {56'h0, hb_rdata}, {56'h0, e});
            end
        end
    end

    task automatic strobe(input logic s, input logic p, input logic w, input logic r, input logic [7:0] b);
        hb_start = s; hb_stop = p; hb_wr = w; hb_rd = r; hb_byte = b;
        @(negedge clk);
        hb_start = 0; hb_stop = 0; hb_wr = 0; hb_rd = 0; hb_byte = 8'h00;
    endtask

    function automatic logic [7:0] cmd_byte(input logic ai, input int rix, input int bank);
        return {ai, 7'((rix << 3) + bank)};
    endfunction

    task automatic cmd(input logic ai, input int rix, input int bank);
        strobe(1, 0, 0, 0, cmd_byte(ai, rix, bank));
    endtask
    task automatic wbyte(input logic [7:0] d);
        strobe(0, 0, 1, 0, d);
    endtask
    task automatic rbyte(input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        strobe(0, 0, 0, 1, 8'h00);
    endtask
    task automatic stop();
        strobe(0, 1, 0, 0, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_out", 64'(pin_out), 64'(40'hFF_FF_FF_FF_FF));
        check("R1 pin_oe", 64'(pin_oe), 64'h0);
        check("R1 rvalid", 64'(hb_rvalid), 64'h0);
        cmd(0, 3, 4); rbyte(8'hFF, "R1 dir");
        cmd(0, 2, 0); rbyte(8'h00, "R1 inv");
        cmd(0, 1, 2); rbyte(8'hFF, "R1 out"); stop();

        // R3 output write
        cmd(0, 1, 0); wbyte(8'hA5); stop();
        check("R3 pin_out", 64'(pin_out), 64'(40'hFF_FF_FF_FF_A5));
        // R4 direction
        cmd(0, 3, 0); wbyte(8'h0F); stop();
        check("R4 pin_oe", 64'(pin_oe), 64'(40'h00_00_00_00_F0));
        check("R4 driven", 64'(pin_out[7:4]), 64'hA);

        // R7 auto-increment with wrap
        cmd(1, 1, 3); wbyte(8'h11); wbyte(8'h22); wbyte(8'h33); stop();
        check("R7 pin_out", 64'(pin_out), 64'(40'h22_11_FF_FF_33));
        cmd(1, 1, 4);
        rbyte(8'h22, "R7 rd b4"); rbyte(8'h33, "R7 rd wrap b0"); rbyte(8'hFF, "R7 rd b1");
        stop();

        // R8 no auto-increment
        cmd(0, 2, 1); wbyte(8'h3C); wbyte(8'hC3); stop();
        cmd(1, 2, 1); rbyte(8'hC3, "R8 inv b1"); rbyte(8'h00, "R8 inv b2"); stop();

        // R5 input read with inversion
        pin_in = 40'h12_34_56_78_9A;
        repeat (2) @(negedge clk);
        cmd(1, 0, 0);
        rbyte(8'h9A, "R5 in b0"); rbyte(8'hBB, "R5 in b1 inverted"); rbyte(8'h56, "R5 in b2");
        stop();

        // R6 input write ignored
        cmd(0, 0, 0); wbyte(8'h55); stop();
        check("R6 pin_out", 64'(pin_out), 64'(40'h22_11_FF_FF_33));
        cmd(0, 0, 0); rbyte(8'h9A, "R6 in b0"); stop();
        cmd(0, 2, 0); rbyte(8'h00, "R6 inv b0"); stop();

        // R9 strobes with no transaction
        wbyte(8'h00);
        strobe(0, 0, 0, 1, 8'h00);
        repeat (2) @(negedge clk);
        check("R9 pin_out", 64'(pin_out), 64'(40'h22_11_FF_FF_33));
        check("R9 pin_oe", 64'(pin_oe), 64'(40'h00_00_00_00_F0));

        // R10 out-of-range pointer
        cmd(0, 1, 6); wbyte(8'h00); stop();
        check("R10 pin_out", 64'(pin_out), 64'(40'h22_11_FF_FF_33));
        cmd(0, 1, 6); rbyte(8'h00, "R10 rd bank6"); stop();
        cmd(0, 5, 0); wbyte(8'h00); rbyte(8'h00, "R10 rd reg5"); stop();
        check("R10 pin_oe", 64'(pin_oe), 64'(40'h00_00_00_00_F0));

        // R11 repeated start
        cmd(1, 1, 2); cmd(0, 1, 1); wbyte(8'h77); stop();
        check("R11 pin_out", 64'(pin_out), 64'(40'h22_11_FF_77_33));

        // R2 pointer encoding: direction bank 4 at pointer 28
        strobe(1, 0, 0, 0, 8'd28); wbyte(8'h00); stop();
        check("R2 pin_oe", 64'(pin_oe), 64'(40'hFF_00_00_00_F0));
        check("R2 pin_out", 64'(pin_out[39:32]), 64'h22);

        repeat (3) @(negedge clk);
        check("R5 all reads returned", 64'(exp_q.size()), 64'h0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule